// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block turns characters into frames on a single asynchronous serial line. A character written through a load strobe waits in a one-entry holding register. When the line is free, it moves into a shift register and goes out as a start bit, the data bits with the least significant first, and a stop bit. Characters carry eight or nine data bits. When parity is enabled, the top data position carries a parity bit instead, so the frame keeps its length.

Bit timing comes from an internal 13-bit modulus divider clocked by the module clock. The divider makes a sixteen-times oversampling tick, and each bit on the line lasts sixteen ticks. The divisor is therefore the clock frequency divided by sixteen times the baud rate; for example, 26 at 4 MHz gives roughly 9600 baud. A break request replaces characters with whole frames of zeros at the next frame boundary. When the request is withdrawn, a stop bit is sent before any further character.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever nothing is being sent, `txd` is 1, `busy` is 0, and `hold_empty` is 1 once no character is pending.
- R2: A frame is a start bit of 0, then the data bits of `tx_data` with bit 0 first, then a stop bit of 1. With `wide_mode`=0 the frame is 10 bits long and uses `tx_data[7:0]`, so bit 8 has no effect.
- R3: With `wide_mode`=1 the frame carries all nine bits `tx_data[8:0]` and is 11 bits long.
- R4: With `par_en`=1 the highest data position (bit 7 when `wide_mode`=0, bit 8 when `wide_mode`=1) carries a parity bit instead of data. The parity covers the data bits below that position. With `par_odd`=0 the total count of ones in the data positions is even; with `par_odd`=1 it is odd. The frame length is unchanged.
- R5: Every bit on the line lasts exactly 16 × `divisor` clock cycles.
- R6: While `divisor` is 0 the generator produces no ticks and `txd` holds its level. Once a non-zero divisor is applied, the frame resumes.
- R7: A `tx_load` pulse writes `tx_data` into the holding register and drives `hold_empty` to 0 on the next cycle. The held character starts at the next frame boundary, which sets `hold_empty` back to 1. A character loaded during a frame starts immediately after that frame's stop bit. A second load before the character has started replaces it.
- R8: While `brk_req` is 1, the line sends whole frames of zeros, each as long as a character frame in the current mode. A character already on the line is finished first, and a request from idle starts a break frame on the next cycle.
- R9: After `brk_req` falls, the current break frame completes and is followed by at least one stop bit of 1 before any pending character starts.
- R10: `busy` is 1 from the first cycle of a start bit or break frame until the end of the last stop bit, and the bit sent just before `busy` falls is a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock, also the source of the baud divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 13 | Baud divisor; 0 stops the generator |
| tx_data | input | 9 | Character to send |
| tx_load | input | 1 | One-cycle strobe that writes `tx_data` into the holding register |
| wide_mode | input | 1 | 0 = eight data bits, 1 = nine data bits |
| par_en | input | 1 | 1 = top data position carries parity |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| brk_req | input | 1 | Hold at 1 to send break frames |
| txd | output | 1 | Serial line output, idles at 1 |
| busy | output | 1 | A frame, break or trailing stop bit is in progress |
| hold_empty | output | 1 | Holding register can take a new character |

## Verification
The bench samples every bit in its middle. Three kinds of error would show up there: a wrong divisor scaling would move a bit boundary, a parity bit appended instead of substituted would stretch the frame, and an inverted parity sense would flip one bit. Back-to-back loads check two things: that the buffered character follows the stop bit with no idle gap, and that the second load overwrites the first, so a design that queued both or dropped the newer one would send the wrong character. Break is raised both from idle and in the middle of a character. A design that cut the character short, ended the break mid-frame, or skipped the stop bit after release would put zeros where ones belong. A zero divisor must freeze the start bit rather than let it run on.

// File: rtl/async_tx_pkg.sv
`timescale 1ns/1ps
package async_tx_pkg;

    // Transmit sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // line high, waiting for work
        ST_CHAR  = 2'd1,   // shifting a character frame
        ST_BREAK = 2'd2,   // sending a frame of zeros
        ST_MARK  = 2'd3    // single stop bit after a break
    } tx_state_e;

endpackage

// File: rtl/async_tx_baud.sv
`timescale 1ns/1ps
module async_tx_baud #(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_end
);

    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] PHASE_LAST = OVS_W'(OVS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [OVS_W-1:0] phase;
    } baud_t;

    baud_t q, d;
    logic  enabled;
    logic  wrap;

    always_comb begin
        d       = q;
        enabled = run && (divisor != '0);
        wrap    = enabled && (q.cnt >= (divisor - 1'b1));
        bit_end = wrap && (q.phase == PHASE_LAST);
        if (!run) begin
            d = '0;
        end else if (enabled) begin
            if (wrap) begin
                d.cnt   = '0;
                d.phase = bit_end ? '0 : q.phase + 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/async_tx_framer.sv
`timescale 1ns/1ps
module async_tx_framer #(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0]               data,
    input  logic                            wide,
    input  logic                            par_en,
    input  logic                            par_odd,
    output logic [DATA_W+1:0]               frame,
    output logic [$clog2(DATA_W+2)-1:0]     last_idx
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);

    logic [DATA_W-1:0] below_top;
    logic              parity;

    always_comb begin
        below_top = wide ? {1'b0, {(DATA_W-1){1'b1}}}
                         : {2'b00, {(DATA_W-2){1'b1}}};
        parity    = par_odd ^ (^(data & below_top));
        last_idx  = wide ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W);
    end

    assign frame[0] = 1'b0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_slot
        localparam logic IN_NARROW  = (i <= DATA_W - 2);
        localparam logic TOP_NARROW = (i == DATA_W - 2);
        localparam logic TOP_WIDE   = (i == DATA_W - 1);
        logic present;
        logic is_top;
        assign present = wide | IN_NARROW;
        assign is_top  = wide ? TOP_WIDE : TOP_NARROW;
        assign frame[i+1] = !present          ? 1'b1   :
                            (par_en && is_top) ? parity : data[i];
    end

    assign frame[FRAME_W-1] = 1'b1;

endmodule

// File: rtl/async_tx.sv
`timescale 1ns/1ps
module async_tx
    import async_tx_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              wide_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              brk_req,
    output logic              txd,
    output logic              busy,
    output logic              hold_empty
);

    localparam int FRAME_W = DATA_W + 2;
    localparam int IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] sr;
        logic [IDX_W-1:0]   left;
        logic               line;
        logic [DATA_W-1:0]  hold;
        logic               hold_full;
    } tx_t;

    localparam tx_t TX_RST = '{
        st:        ST_IDLE,
        sr:        '1,
        left:      '0,
        line:      1'b1,
        hold:      '0,
        hold_full: 1'b0
    };

    tx_t                q, d;
    logic               run;
    logic               bit_end;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   last_idx;
    logic               boundary;

    assign run = (q.st != ST_IDLE);

    async_tx_baud #(
        .DIV_W (DIV_W),
        .OVS   (OVS)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .divisor (divisor),
        .bit_end (bit_end)
    );

    async_tx_framer #(
        .DATA_W (DATA_W)
    ) u_framer (
        .data     (q.hold),
        .wide     (wide_mode),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .frame    (frame),
        .last_idx (last_idx)
    );

    always_comb begin
        d        = q;
        boundary = 1'b0;

        case (q.st)
            ST_IDLE: begin
                boundary = 1'b1;
            end
            ST_CHAR: begin
                if (bit_end) begin
                    if (q.left != '0) begin
                        d.sr   = q.sr >> 1;
                        d.line = q.sr[1];
                        d.left = q.left - 1'b1;
                    end else begin
                        boundary = 1'b1;
                    end
                end
            end
            ST_BREAK: begin
                if (bit_end) begin
                    if (q.left != '0) begin
                        d.left = q.left - 1'b1;
                    end else if (brk_req) begin
                        d.left = last_idx;
                    end else begin
                        d.st   = ST_MARK;
                        d.line = 1'b1;
                        d.left = '0;
                    end
                end
            end
            ST_MARK: begin
                if (bit_end) boundary = 1'b1;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        // Decide what follows a finished frame (or idle)
        if (boundary) begin
            if (brk_req) begin
                d.st   = ST_BREAK;
                d.line = 1'b0;
                d.left = last_idx;
            end else if (q.hold_full) begin
                d.st        = ST_CHAR;
                d.sr        = frame;
                d.line      = frame[0];
                d.left      = last_idx;
                d.hold_full = 1'b0;
            end else begin
                d.st   = ST_IDLE;
                d.line = 1'b1;
                d.left = '0;
            end
        end

        // A new write always lands in the holding register
        if (tx_load) begin
            d.hold      = tx_data;
            d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TX_RST;
        else        q <= d;
    end

    assign txd        = q.line;
    assign busy       = (q.st != ST_IDLE);
    assign hold_empty = !q.hold_full;

endmodule

// File: rtl/async_tx_chk.sv
`timescale 1ns/1ps
module async_tx_chk #(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] divisor,
    input logic             tx_load,
    input logic             brk_req,
    input logic             txd,
    input logic             busy,
    input logic             hold_empty
);

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);  // R1

    AST_FRAME_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);  // R2

    AST_LAST_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd));  // R10

    AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !hold_empty);  // R7

    AST_PENDING_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !busy) |=> busy);  // R7

    AST_DIV_ZERO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && divisor == '0) |=> $stable(txd));  // R6

    AST_BREAK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && brk_req) |=> (busy && !txd));  // R8

endmodule

bind async_tx async_tx_chk #(
    .DIV_W (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .divisor    (divisor),
    .tx_load    (tx_load),
    .brk_req    (brk_req),
    .txd        (txd),
    .busy       (busy),
    .hold_empty (hold_empty)
);

// File: tb/async_tx_tb.sv
`timescale 1ns/1ps
module async_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] divisor;
    logic [8:0]  tx_data;
    logic        tx_load;
    logic        wide_mode;
    logic        par_en;
    logic        par_odd;
    logic        brk_req;
    logic        txd;
    logic        busy;
    logic        hold_empty;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    async_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .divisor    (divisor),
        .tx_data    (tx_data),
        .tx_load    (tx_load),
        .wide_mode  (wide_mode),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .brk_req    (brk_req),
        .txd        (txd),
        .busy       (busy),
        .hold_empty (hold_empty)
    );

    // {divisor, wide, parity enable, odd, data}
    localparam logic [24:0] VEC [8] = '{
        {13'd1, 1'b0, 1'b0, 1'b0, 9'h0A5},
        {13'd1, 1'b0, 1'b1, 1'b0, 9'h053},
        {13'd1, 1'b0, 1'b1, 1'b1, 9'h053},
        {13'd2, 1'b1, 1'b0, 1'b0, 9'h1C3},
        {13'd1, 1'b1, 1'b1, 1'b0, 9'h0FF},
        {13'd1, 1'b1, 1'b1, 1'b1, 9'h100},
        {13'd3, 1'b0, 1'b0, 1'b0, 9'h1FF},
        {13'd1, 1'b0, 1'b1, 1'b1, 9'h000}
    };

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Expected frame from the requirements: start, data LSB first, parity in top slot, stop
    function automatic logic [10:0] exp_frame(input logic [8:0] dat, input logic m9,
                                              input logic pe, input logic po);
        int   nd = m9 ? 9 : 8;
        logic p  = po;
        logic [10:0] f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd - 1; i++) p ^= dat[i];
        for (int i = 0; i < nd; i++) f[i+1] = dat[i];
        if (pe) f[nd] = p;
        return f;
    endfunction

    function automatic int frame_len(input logic m9);
        return m9 ? 11 : 10;
    endfunction

    task automatic load(input logic [8:0] dat);
        tx_data = dat;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_fall(input string req);
        int guard = 0;
        while (txd === 1'b1 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(req, "line fell", txd, 1'b0);
    endtask

    // Samples each bit at its centre; actions happen right after a sample
    task automatic stream(input int dv, input int nb, input logic [63:0] exp,
                          input string req, input int brk_on, input int brk_off,
                          input int ld1, input logic [8:0] d1,
                          input int ld2, input logic [8:0] d2);
        repeat (8*dv - 1) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (i > 0) begin
                @(negedge clk);
                tx_load = 1'b0;
                repeat (16*dv - 1) @(negedge clk);
            end
            check(req, $sformatf("bit %0d", i), txd, exp[i]);
            if (ld1 >= 0 && i == ld1 + 1) check("R7", "held after load", hold_empty, 1'b0);
            if (i == brk_on)  brk_req = 1'b1;
            if (i == brk_off) brk_req = 1'b0;
            if (i == ld1) begin tx_data = d1; tx_load = 1'b1; end
            if (i == ld2) begin tx_data = d2; tx_load = 1'b1; end
        end
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Called right after the centre of the last stop bit has been sampled plus one negedge
    task automatic idle_check(input int dv, input string req);
        repeat (8*dv) @(negedge clk);
        check(req, "busy low after frame", busy, 1'b0);
        check("R1", "line idle high", txd, 1'b1);
        check("R1", "holding empty", hold_empty, 1'b1);
    endtask

    function automatic logic [63:0] place(input logic [63:0] base, input int off,
                                          input logic [10:0] f, input int len);
        logic [63:0] r = base;
        for (int i = 0; i < len; i++) r[off+i] = f[i];
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] e;
        rst_n     = 1'b0;
        divisor   = 13'd1;
        tx_data   = '0;
        tx_load   = 1'b0;
        wide_mode = 1'b0;
        par_en    = 1'b0;
        par_odd   = 1'b0;
        brk_req   = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check("R1", "reset txd", txd, 1'b1);
        check("R1", "reset busy", busy, 1'b0);
        check("R1", "reset hold_empty", hold_empty, 1'b1);

        // Vector table: framing, width, parity and bit timing (R2 R3 R4 R5)
        for (int v = 0; v < 8; v++) begin
            int          dv  = int'(VEC[v][24:12]);
            logic        m9  = VEC[v][11];
            logic        pe  = VEC[v][10];
            logic        po  = VEC[v][9];
            logic [8:0]  dat = VEC[v][8:0];
            string       req = pe ? "R4" : (m9 ? "R3" : (dv > 1 ? "R5" : "R2"));
            divisor   = 13'(dv);
            wide_mode = m9;
            par_en    = pe;
            par_odd   = po;
            load(dat);
            wait_fall(req);
            e = place('0, 0, exp_frame(dat, m9, pe, po), frame_len(m9));
            stream(dv, frame_len(m9), e, req, -1, -1, -1, '0, -1, '0);
            idle_check(dv, "R10");
        end

        // R7: back-to-back with overwrite of the pending character
        divisor = 13'd1; wide_mode = 1'b0; par_en = 1'b0; par_odd = 1'b0;
        load(9'h03C);
        wait_fall("R7");
        e = place('0, 0, exp_frame(9'h03C, 1'b0, 1'b0, 1'b0), 10);
        e = place(e, 10, exp_frame(9'h07E, 1'b0, 1'b0, 1'b0), 10);
        stream(1, 20, e, "R7", -1, -1, 0, 9'h081, 1, 9'h07E);
        idle_check(1, "R7");

        // R8 R9: break from idle, release mid second frame, pending char after stop
        brk_req = 1'b1;
        @(negedge clk);
        check("R8", "break starts low", txd, 1'b0);
        e = '0;
        e[20] = 1'b1;
        e = place(e, 21, exp_frame(9'h055, 1'b0, 1'b0, 1'b0), 10);
        stream(1, 31, e, "R9", -1, 12, 12, 9'h055, -1, '0);
        idle_check(1, "R9");

        // R8: break requested during a character, character completes first
        load(9'h00F);
        wait_fall("R8");
        e = place('0, 0, exp_frame(9'h00F, 1'b0, 1'b0, 1'b0), 10);
        e[20] = 1'b1;
        stream(1, 21, e, "R8", 3, 15, -1, '0, -1, '0);
        idle_check(1, "R8");

        // R6: divisor zero freezes the line in the start bit
        divisor = 13'd0;
        load(9'h033);
        wait_fall("R6");
        for (int k = 0; k < 4; k++) begin
            repeat (50) @(negedge clk);
            check("R6", "line frozen low", txd, 1'b0);
            check("R6", "still busy", busy, 1'b1);
        end
        divisor = 13'd1;
        begin
            int guard = 0;
            while (busy === 1'b1 && guard < 400) begin
                @(negedge clk);
                guard++;
            end
        end
        check("R6", "frame resumed and ended", busy, 1'b0);
        check("R6", "line high after resume", txd, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule